// File: doc/BRIEF.md
# Compressed Half-Word Instruction Decoder

This block sits behind the fetch aligner of a core whose normal instructions are 32 bits wide. It watches the leading half-word of each 32-bit instruction. When that half-word carries the reserved entry opcode in its top five bits, the remaining eleven bits are decoded as a compressed instruction. From then on every half-word is treated as compressed for as long as the lowest bit of the previous one asks for it.

Each compressed instruction becomes one registered micro-op record. The record holds a unit class, a two-bit operation code, two 3-bit register numbers, branch condition fields, a link flag, condition-field move operands and a sign-extended byte offset for relative branches. The block also drives a mode flag, which tells the aligner whether to step by two or by four bytes. It drives a one-cycle exit pulse when a decoded instruction ends compressed mode. Executing the operations is not part of this block.

Bits are named 0 (most significant) to f (least significant). Bit k sits on `hw_data[15-k]`.

Top module: `cmp16_decoder`

## Requirements
- R1: After reset, and while `rst_n` is low, `mode_cmp`, `uop_valid` and `exit_pulse` are 0.
- R2: In 32-bit mode, a valid half-word whose bits 0-4 differ from `ENTRY_OP` (default 6) produces no micro-op and leaves `mode_cmp` at 0.
- R3: In 32-bit mode, a valid half-word whose bits 0-4 equal `ENTRY_OP` is decoded from its bits 5-f. One cycle later `uop_valid` is 1 and `mode_cmp` equals its bit f.
- R4: In compressed mode, every valid half-word is decoded, whatever its bits 0-4 hold, and `mode_cmp` then follows its bit f. A cycle with `hw_valid` low gives no micro-op and leaves the mode unchanged.
- R5: `exit_pulse` is 1 for exactly the cycle in which a decoded micro-op is shown whose bit f was 0. In that cycle `mode_cmp` is 0.
- R6: Bits 5-7 give the unit code on `uop_unit`: 000 gives branch (0). 001 gives condition move (1) when bits 8-9 are 00, and branch (0) otherwise. 010 and 011 give integer (2), 100 and 101 give logical (3), 110 and 111 give floating point (4).
- R7: For the integer, logical and floating-point units, `uop_ra` is bits 8-a and `uop_rb` is bits b-d. `uop_op` is {bit 7, bit e}. This encodes add/mul/sub/cmp for integer and float, and and/nand/or/nor for logical.
- R8: Group 001 with bits 8-9 nonzero is a register branch. `uop_op` is bits 8-9 (1 link register, 2 target register, 3 count register). `uop_bi` is bits a-b. `uop_cond_chk` is bit c and `uop_cond_inv` is bit d. `uop_lk` is bit e.
- R9: Group 000 is a relative branch with `uop_op` 0 and `uop_lk` equal to bit e. `uop_offs` is bits 8-d read as a signed 6-bit count of half-words, shifted left by one and sign-extended to `OFFS_W` bits.
- R10: Group 001 with bits 8-9 equal to 00 is a condition-field move. `uop_crf_dst` is bits a-b, `uop_crf_src` is bits c-d, and `uop_op` is 0.
- R11: Every record field that the decoded unit does not use reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | A half-word is presented this cycle |
| hw_data | input | 16 | Half-word, bit 0 on index 15 |
| mode_cmp | output | 1 | 1 = compressed mode (step 2 bytes), 0 = 32-bit mode |
| uop_valid | output | 1 | Micro-op record is valid this cycle |
| uop_unit | output | 3 | Unit class code |
| uop_op | output | 2 | Operation within the unit |
| uop_ra | output | 3 | First register number |
| uop_rb | output | 3 | Second register number |
| uop_bi | output | 2 | Condition bit index within CR0 |
| uop_cond_chk | output | 1 | Branch tests the condition bit |
| uop_cond_inv | output | 1 | Branch inverts the condition test |
| uop_lk | output | 1 | Branch writes the link register |
| uop_crf_dst | output | 2 | Destination condition field |
| uop_crf_src | output | 2 | Source condition field |
| uop_offs | output | OFFS_W | Sign-extended byte offset of a relative branch |
| exit_pulse | output | 1 | Decoded micro-op returns the stream to 32-bit mode |

## Verification
The bound checker watches the mode rules on every cycle. It checks that idle cycles hold the mode, that a non-entry half-word in 32-bit mode is dropped, and that the exit pulse coincides with a valid record and a cleared mode flag. It also checks that unused fields stay zero for each unit class. Field extraction can only be shown by the bench's scenarios: the register, condition and offset values of each group, offset sign extension at both ends of its range, and the entry half-word that carries its own instruction. The same holds for reset during compressed mode.

// File: rtl/cmp16_decoder.sv
module cmp16_decoder #(
  parameter logic [4:0] ENTRY_OP = 5'd6,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  input  logic [15:0]       hw_data,
  output logic              mode_cmp,
  output logic              uop_valid,
  output logic [2:0]        uop_unit,
  output logic [1:0]        uop_op,
  output logic [2:0]        uop_ra,
  output logic [2:0]        uop_rb,
  output logic [1:0]        uop_bi,
  output logic              uop_cond_chk,
  output logic              uop_cond_inv,
  output logic              uop_lk,
  output logic [1:0]        uop_crf_dst,
  output logic [1:0]        uop_crf_src,
  output logic [OFFS_W-1:0] uop_offs,
  output logic              exit_pulse
);
  localparam logic [2:0] U_BR  = 3'd0;
  localparam logic [2:0] U_CR  = 3'd1;
  localparam logic [2:0] U_INT = 3'd2;
  localparam logic [2:0] U_LOG = 3'd3;
  localparam logic [2:0] U_FP  = 3'd4;
  localparam int EXT_W = OFFS_W - 7;

  logic [2:0] grp, fa, fb;
  logic       fe, cont, take;

  assign grp  = hw_data[10:8];
  assign fa   = hw_data[7:5];
  assign fb   = hw_data[4:2];
  assign fe   = hw_data[1];
  assign cont = hw_data[0];
  assign take = hw_valid && (mode_cmp || hw_data[15:11] == ENTRY_OP);

  logic [2:0]        d_unit;
  logic [1:0]        d_op, d_bi, d_dst, d_src;
  logic [2:0]        d_ra, d_rb;
  logic              d_chk, d_inv, d_lk;
  logic [OFFS_W-1:0] d_offs;

  always_comb begin
    d_unit = U_BR;
    d_op   = 2'd0;
    d_ra   = 3'd0;
    d_rb   = 3'd0;
    d_bi   = 2'd0;
    d_chk  = 1'b0;
    d_inv  = 1'b0;
    d_lk   = 1'b0;
    d_dst  = 2'd0;
    d_src  = 2'd0;
    d_offs = '0;
    case (grp)
      3'd0: begin
        d_lk   = fe;
        d_offs = {{EXT_W{fa[2]}}, fa, fb, 1'b0};
      end
      3'd1: begin
        if (fa[2:1] == 2'b00) begin
          d_unit = U_CR;
          d_dst  = {fa[0], fb[2]};
          d_src  = fb[1:0];
        end else begin
          d_op  = fa[2:1];
          d_bi  = {fa[0], fb[2]};
          d_chk = fb[1];
          d_inv = fb[0];
          d_lk  = fe;
        end
      end
      default: begin
        d_unit = (grp[2:1] == 2'b01) ? U_INT : (grp[2:1] == 2'b10) ? U_LOG : U_FP;
        d_op   = {grp[0], fe};
        d_ra   = fa;
        d_rb   = fb;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cmp   <= 1'b0;
      uop_valid  <= 1'b0;
      exit_pulse <= 1'b0;
    end else begin
      uop_valid  <= take;
      exit_pulse <= take && !cont;
      if (take) mode_cmp <= cont;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uop_unit     <= U_BR;
      uop_op       <= 2'd0;
      uop_ra       <= 3'd0;
      uop_rb       <= 3'd0;
      uop_bi       <= 2'd0;
      uop_cond_chk <= 1'b0;
      uop_cond_inv <= 1'b0;
      uop_lk       <= 1'b0;
      uop_crf_dst  <= 2'd0;
      uop_crf_src  <= 2'd0;
      uop_offs     <= '0;
    end else if (take) begin
      uop_unit     <= d_unit;
      uop_op       <= d_op;
      uop_ra       <= d_ra;
      uop_rb       <= d_rb;
      uop_bi       <= d_bi;
      uop_cond_chk <= d_chk;
      uop_cond_inv <= d_inv;
      uop_lk       <= d_lk;
      uop_crf_dst  <= d_dst;
      uop_crf_src  <= d_src;
      uop_offs     <= d_offs;
    end
  end
endmodule

// File: rtl/cmp16_decoder_chk.sv
module cmp16_decoder_chk #(
  parameter logic [4:0] ENTRY_OP = 5'd6,
  parameter int OFFS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_valid,
  input logic [15:0]       hw_data,
  input logic              mode_cmp,
  input logic              uop_valid,
  input logic [2:0]        uop_unit,
  input logic [1:0]        uop_op,
  input logic [2:0]        uop_ra,
  input logic [2:0]        uop_rb,
  input logic [1:0]        uop_bi,
  input logic              uop_cond_chk,
  input logic              uop_cond_inv,
  input logic              uop_lk,
  input logic [1:0]        uop_crf_dst,
  input logic [1:0]        uop_crf_src,
  input logic [OFFS_W-1:0] uop_offs,
  input logic              exit_pulse
);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_valid |=> !uop_valid && $stable(mode_cmp));

  p_no_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !mode_cmp && hw_data[15:11] != ENTRY_OP) |=> !uop_valid && !mode_cmp);

  p_exit_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> uop_valid && !mode_cmp);

  p_exit_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && mode_cmp && !hw_data[0]) |=> exit_pulse);

  p_unit_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> uop_unit <= 3'd4);

  p_alu_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_unit >= 3'd2) |->
      uop_bi == 2'd0 && !uop_cond_chk && !uop_cond_inv && !uop_lk &&
      uop_crf_dst == 2'd0 && uop_crf_src == 2'd0 && uop_offs == '0);

  p_crmove_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_unit == 3'd1) |->
      uop_op == 2'd0 && uop_ra == 3'd0 && uop_rb == 3'd0 && !uop_lk && uop_offs == '0);

  p_branch_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_unit == 3'd0) |->
      uop_ra == 3'd0 && uop_rb == 3'd0 && uop_crf_dst == 2'd0 && uop_crf_src == 2'd0);

  p_rel_no_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_unit == 3'd0 && uop_op == 2'd0) |->
      !uop_cond_chk && !uop_cond_inv && uop_bi == 2'd0);
endmodule

bind cmp16_decoder cmp16_decoder_chk #(.ENTRY_OP(ENTRY_OP), .OFFS_W(OFFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
  .mode_cmp(mode_cmp), .uop_valid(uop_valid), .uop_unit(uop_unit), .uop_op(uop_op),
  .uop_ra(uop_ra), .uop_rb(uop_rb), .uop_bi(uop_bi), .uop_cond_chk(uop_cond_chk),
  .uop_cond_inv(uop_cond_inv), .uop_lk(uop_lk), .uop_crf_dst(uop_crf_dst),
  .uop_crf_src(uop_crf_src), .uop_offs(uop_offs), .exit_pulse(exit_pulse)
);

// File: tb/cmp16_decoder_tb_top.sv
module cmp16_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw_data = 16'd0;
  logic        mode_cmp, uop_valid, uop_cond_chk, uop_cond_inv, uop_lk, exit_pulse;
  logic [2:0]  uop_unit, uop_ra, uop_rb;
  logic [1:0]  uop_op, uop_bi, uop_crf_dst, uop_crf_src;
  logic [15:0] uop_offs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp16_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .mode_cmp(mode_cmp), .uop_valid(uop_valid), .uop_unit(uop_unit), .uop_op(uop_op),
    .uop_ra(uop_ra), .uop_rb(uop_rb), .uop_bi(uop_bi), .uop_cond_chk(uop_cond_chk),
    .uop_cond_inv(uop_cond_inv), .uop_lk(uop_lk), .uop_crf_dst(uop_crf_dst),
    .uop_crf_src(uop_crf_src), .uop_offs(uop_offs), .exit_pulse(exit_pulse)
  );

  // stimulus {grp, a, b, e} then expected
  // {unit, op, ra, rb, bi, chk, inv, lk, crf_dst, crf_src, offs}
  localparam int NV = 21;
  localparam logic [45:0] VEC [NV] = '{
    {3'd2,3'd5,3'd3,1'b0, 3'd2,2'd0,3'd5,3'd3,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd2,3'd1,3'd7,1'b1, 3'd2,2'd1,3'd1,3'd7,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd3,3'd0,3'd6,1'b0, 3'd2,2'd2,3'd0,3'd6,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd3,3'd7,3'd0,1'b1, 3'd2,2'd3,3'd7,3'd0,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd4,3'd2,3'd4,1'b0, 3'd3,2'd0,3'd2,3'd4,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd4,3'd3,3'd2,1'b1, 3'd3,2'd1,3'd3,3'd2,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd5,3'd6,3'd1,1'b0, 3'd3,2'd2,3'd6,3'd1,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd5,3'd4,3'd5,1'b1, 3'd3,2'd3,3'd4,3'd5,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd6,3'd1,3'd2,1'b0, 3'd4,2'd0,3'd1,3'd2,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd6,3'd5,3'd6,1'b1, 3'd4,2'd1,3'd5,3'd6,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd7,3'd2,3'd3,1'b0, 3'd4,2'd2,3'd2,3'd3,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd7,3'd7,3'd7,1'b1, 3'd4,2'd3,3'd7,3'd7,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0000},
    {3'd0,3'd0,3'd5,1'b1, 3'd0,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b1,2'd0,2'd0,16'h000A},
    {3'd0,3'd7,3'd7,1'b0, 3'd0,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'hFFFE},
    {3'd0,3'd4,3'd0,1'b1, 3'd0,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b1,2'd0,2'd0,16'hFFC0},
    {3'd0,3'd3,3'd7,1'b0, 3'd0,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h003E},
    {3'd1,3'd2,3'd6,1'b1, 3'd0,2'd1,3'd0,3'd0,2'd1,1'b1,1'b0,1'b1,2'd0,2'd0,16'h0000},
    {3'd1,3'd5,3'd3,1'b0, 3'd0,2'd2,3'd0,3'd0,2'd2,1'b1,1'b1,1'b0,2'd0,2'd0,16'h0000},
    {3'd1,3'd7,3'd5,1'b1, 3'd0,2'd3,3'd0,3'd0,2'd3,1'b0,1'b1,1'b1,2'd0,2'd0,16'h0000},
    {3'd1,3'd1,3'd6,1'b0, 3'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b0,2'd3,2'd2,16'h0000},
    {3'd1,3'd0,3'd1,1'b1, 3'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b0,2'd0,2'd1,16'h0000}
  };

  function automatic logic [35:0] rec();
    return {uop_unit, uop_op, uop_ra, uop_rb, uop_bi, uop_cond_chk, uop_cond_inv,
            uop_lk, uop_crf_dst, uop_crf_src, uop_offs};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] h);
    @(negedge clk);
    hw_valid = 1'b1;
    hw_data  = h;
    @(posedge clk);
    #1;
    hw_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    hw_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: non-entry half-word in 32-bit mode ignored
    send({5'd7, 3'd2, 3'd1, 3'd1, 1'b0, 1'b1});
    check("R2", {34'd0, mode_cmp, uop_valid}, 36'd0);

    // R3: entry half-word carries integer add, continuation set
    send({5'd6, 3'd2, 3'd1, 3'd2, 1'b0, 1'b1});
    check("R3", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'b110);
    check("R3_R7", rec(), {3'd2,2'd0,3'd1,3'd2,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0});

    // R4/R6-R10 table walk in compressed mode; odd entries put junk in bits 0-4
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      string tg;
      v = VEC[i];
      send({(i % 2 == 1) ? 5'h1F : 5'h00, v[45:43], v[42:40], v[39:37], v[36], 1'b1});
      if (v[45:43] == 3'd0) tg = "R6_R9";
      else if (v[45:43] == 3'd1 && v[42:41] == 2'b00) tg = "R6_R10";
      else if (v[45:43] == 3'd1) tg = "R6_R8";
      else tg = "R6_R7";
      check(tg, rec(), v[35:0]);
      check("R4", {34'd0, mode_cmp, uop_valid}, 36'b11);
    end

    // R4: idle cycle keeps mode and gives no micro-op
    idle();
    check("R4", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'b100);

    // R5: continuation clear ends compressed mode
    send({5'h00, 3'd4, 3'd6, 3'd5, 1'b1, 1'b0});
    check("R5", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'b011);
    check("R5_R11", rec(), {3'd3,2'd1,3'd6,3'd5,2'd0,1'b0,1'b0,1'b0,2'd0,2'd0,16'h0});
    idle();
    check("R5", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'd0);

    // R2: compressed-looking half-word is ignored back in 32-bit mode
    send({5'h00, 3'd0, 3'd0, 3'd5, 1'b1, 1'b1});
    check("R2", {34'd0, mode_cmp, uop_valid}, 36'd0);

    // R3: one-shot entry with continuation clear
    send({5'd6, 3'd0, 3'd4, 3'd0, 1'b1, 1'b0});
    check("R3_R5", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'b011);
    check("R3_R9", rec(), {3'd0,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,1'b1,2'd0,2'd0,16'hFFC0});

    // R1: reset during compressed mode
    send({5'd6, 3'd2, 3'd3, 3'd3, 1'b0, 1'b1});
    check("R3", {34'd0, mode_cmp, uop_valid}, 36'b11);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {33'd0, mode_cmp, uop_valid, exit_pulse}, 36'd0);
    @(negedge clk);
    rst_n = 1'b1;
    send({5'h00, 3'd2, 3'd3, 3'd3, 1'b0, 1'b1});
    check("R1_R2", {34'd0, mode_cmp, uop_valid}, 36'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule